// File: doc/BRIEF.md
# Two-Stage Parallel Argmax Tree

This block finds the largest entry of a long vector of non-negative magnitudes, together with the position of that entry. The vector arrives as a stream of fixed-width groups, one group per accepted cycle. Each group is cut into equal slices. Every slice goes through its own max-only comparison tree, and all of these trees work at the same time. A second comparison tree then reduces the slice winners to a single group winner. That winner is merged into a running maximum that covers the whole vector.

Every comparison node carries the value and its index together, so the position of the winner comes out with it. On equal values the lower index always wins. A mask input removes single entries from the contest; a typical use is to drop indices that an iterative solver has already selected. A masked entry competes as the value zero.

The first group of a vector is marked with a start flag, which restarts both the running maximum and the group numbering. The last group is marked with an end flag. The result appears for exactly one cycle, a fixed two register stages after the last group is accepted. The block can take a new group every cycle without gaps, and it ignores idle cycles.

Top module: `argmax_tree`

## Requirements
- R1: The result value max_o equals the largest unmasked entry over all groups accepted from the start-flagged group up to and including the end-flagged group.
- R2: Lane k of a group occupies data_i[k*VAL_W +: VAL_W]. Entry k of group g (the start-flagged group is g=0) has global index g*LANES + k, and idx_o reports the global index of the winning entry.
- R3: When entries are equal, the lower global index wins. This holds inside a slice, between slices of the same group, and between groups.
- R4: mask_i bit k set to 1 makes lane k compete as value 0 while keeping its index. A fully masked vector yields max_o = 0 and idx_o = 0.
- R5: A group accepted with first_i = 1 discards the running maximum and restarts group numbering at 0, even when the previous vector had no end flag.
- R6: When the group with last_i = 1 is accepted at clock edge E, valid_o is 1 only in the cycle between edges E+1 and E+2. Consecutive single-group vectors on consecutive cycles produce results on consecutive cycles.
- R7: A cycle with valid_i = 0 has no effect on the result or on the group numbering, whatever data_i, mask_i, first_i and last_i carry.
- R8: After reset, valid_o, max_o and idx_o are 0. max_o and idx_o keep the last result until the next result is produced.
- R9: A group with both first_i = 1 and last_i = 1 forms a complete one-group vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A group is presented this cycle |
| first_i | input | 1 | Group is the first of a vector |
| last_i | input | 1 | Group is the last of a vector |
| data_i | input | LANES*VAL_W | Unsigned magnitudes, lane k at bits k*VAL_W |
| mask_i | input | LANES | 1 excludes the lane (it competes as zero) |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| max_o | output | VAL_W | Largest unmasked value of the vector |
| idx_o | output | GRP_W+log2(LANES) | Global index of that value |

## Verification
The argmax is exercised with patterns of different kinds. Some vectors have a unique peak in a single group. Others have equal peaks inside one slice, across two slices, or across groups, and these tell a correct lower-index tie-break apart from a reversed or missing one. Other patterns hide larger values behind the mask or mask everything, so a mask that is ignored or inverted shows up. A restart in the middle of a vector, a full-scale value, idle cycles that carry junk flags and data, and back-to-back one-group vectors separate a correct group counter, accumulator reset, valid gating and output timing from designs that get one of these wrong.

// File: rtl/argmax_pkg.sv
package argmax_pkg;
  localparam int unsigned CMP_W = 64;

  // right operand replaces left only when strictly larger: ties keep the lower index
  function automatic logic take_right(input logic [CMP_W-1:0] l_val,
                                      input logic [CMP_W-1:0] r_val);
    return r_val > l_val;
  endfunction
endpackage

// File: rtl/argmax_reduce.sv
module argmax_reduce
  import argmax_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned VAL_W = 16,
  parameter int unsigned IDX_W = 8
) (
  input  logic [N-1:0][VAL_W-1:0] val_i,
  input  logic [N-1:0][IDX_W-1:0] idx_i,
  output logic [VAL_W-1:0]        val_o,
  output logic [IDX_W-1:0]        idx_o
);
  localparam int unsigned LG = $clog2(N);

  for (genvar l = 0; l <= LG; l++) begin : g_lvl
    localparam int unsigned W = N >> l;
    logic [W-1:0][VAL_W-1:0] v;
    logic [W-1:0][IDX_W-1:0] x;
    if (l == 0) begin : g_leaf
      assign v = val_i;
      assign x = idx_i;
    end else begin : g_node
      for (genvar k = 0; k < W; k++) begin : g_cmp
        logic r;
        assign r    = take_right(CMP_W'(g_lvl[l-1].v[2*k]), CMP_W'(g_lvl[l-1].v[2*k+1]));
        assign v[k] = r ? g_lvl[l-1].v[2*k+1] : g_lvl[l-1].v[2*k];
        assign x[k] = r ? g_lvl[l-1].x[2*k+1] : g_lvl[l-1].x[2*k];
      end
    end
  end

  assign val_o = g_lvl[LG].v[0];
  assign idx_o = g_lvl[LG].x[0];
endmodule

// File: rtl/argmax_slice_stage.sv
module argmax_slice_stage #(
  parameter int unsigned LANES      = 8,
  parameter int unsigned SLICE_LOG2 = 2,
  parameter int unsigned VAL_W      = 16,
  parameter int unsigned GRP_W      = 6,
  localparam int unsigned LANE_W    = $clog2(LANES),
  localparam int unsigned IDX_W     = GRP_W + LANE_W,
  localparam int unsigned SLICE     = 1 << SLICE_LOG2,
  localparam int unsigned NSL       = LANES >> SLICE_LOG2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic                        first_i,
  input  logic                        last_i,
  input  logic [LANES*VAL_W-1:0]      data_i,
  input  logic [LANES-1:0]            mask_i,
  output logic                        s1_valid_o,
  output logic                        s1_first_o,
  output logic                        s1_last_o,
  output logic [NSL-1:0][VAL_W-1:0]   win_val_o,
  output logic [NSL-1:0][IDX_W-1:0]   win_idx_o
);
  logic [GRP_W-1:0]              grp_cnt_q, grp_cur;
  logic [LANES-1:0][VAL_W-1:0]   lane_val;
  logic [LANES-1:0][IDX_W-1:0]   lane_idx;
  logic [NSL-1:0][VAL_W-1:0]     win_val_d, win_val_q;
  logic [NSL-1:0][IDX_W-1:0]     win_idx_d, win_idx_q;
  logic                          valid_q, first_q, last_q;

  assign grp_cur = first_i ? '0 : grp_cnt_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_val[k] = mask_i[k] ? '0 : data_i[k*VAL_W +: VAL_W];
    assign lane_idx[k] = {grp_cur, LANE_W'(k)};
  end

  for (genvar s = 0; s < NSL; s++) begin : g_slice
    argmax_reduce #(.N(SLICE), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_tree (
      .val_i (lane_val[s*SLICE +: SLICE]),
      .idx_i (lane_idx[s*SLICE +: SLICE]),
      .val_o (win_val_d[s]),
      .idx_o (win_idx_d[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_cnt_q <= '0;
      valid_q   <= 1'b0;
      first_q   <= 1'b0;
      last_q    <= 1'b0;
      win_val_q <= '0;
      win_idx_q <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        grp_cnt_q <= grp_cur + 1'b1;
        first_q   <= first_i;
        last_q    <= last_i;
        win_val_q <= win_val_d;
        win_idx_q <= win_idx_d;
      end
    end
  end

  assign s1_valid_o = valid_q;
  assign s1_first_o = first_q;
  assign s1_last_o  = last_q;
  assign win_val_o  = win_val_q;
  assign win_idx_o  = win_idx_q;

  assert_all_masked_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (&mask_i)) |=> (win_val_q == '0));

  for (genvar s = 0; s < NSL; s++) begin : g_chk
    assert_restart_group_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && first_i) |=> (win_idx_q[s][IDX_W-1:LANE_W] == '0));
    if (NSL > 1) begin : g_rng
      assert_slice_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> (win_idx_q[s][LANE_W-1:SLICE_LOG2] == (LANE_W-SLICE_LOG2)'(s)));
    end
  end
endmodule

// File: rtl/argmax_merge.sv
module argmax_merge
  import argmax_pkg::*;
#(
  parameter int unsigned NSL   = 2,
  parameter int unsigned VAL_W = 16,
  parameter int unsigned IDX_W = 9
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      s1_valid_i,
  input  logic                      s1_first_i,
  input  logic                      s1_last_i,
  input  logic [NSL-1:0][VAL_W-1:0] win_val_i,
  input  logic [NSL-1:0][IDX_W-1:0] win_idx_i,
  output logic                      valid_o,
  output logic [VAL_W-1:0]          max_o,
  output logic [IDX_W-1:0]          idx_o
);
  logic [VAL_W-1:0] grp_val, acc_val_q, nxt_val, max_q;
  logic [IDX_W-1:0] grp_idx, acc_idx_q, nxt_idx, idx_q;
  logic             valid_q, take_grp;

  argmax_reduce #(.N(NSL), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_tree (
    .val_i (win_val_i),
    .idx_i (win_idx_i),
    .val_o (grp_val),
    .idx_o (grp_idx)
  );

  // earlier groups carry lower indices, so the newer group must be strictly larger
  assign take_grp = s1_first_i || take_right(CMP_W'(acc_val_q), CMP_W'(grp_val));
  assign nxt_val  = take_grp ? grp_val : acc_val_q;
  assign nxt_idx  = take_grp ? grp_idx : acc_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_val_q <= '0;
      acc_idx_q <= '0;
      valid_q   <= 1'b0;
      max_q     <= '0;
      idx_q     <= '0;
    end else begin
      valid_q <= s1_valid_i && s1_last_i;
      if (s1_valid_i) begin
        acc_val_q <= nxt_val;
        acc_idx_q <= nxt_idx;
        if (s1_last_i) begin
          max_q <= nxt_val;
          idx_q <= nxt_idx;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign max_o   = max_q;
  assign idx_o   = idx_q;

  assert_acc_monotone_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_i && !s1_first_i) |=> (acc_val_q >= $past(acc_val_q)));
  assert_result_ge_group_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_i && s1_last_i) |=> (max_o >= $past(grp_val)));
  assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(s1_valid_i && s1_last_i));
  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s1_valid_i && s1_last_i) |=> ($stable(max_o) && $stable(idx_o)));
endmodule

// File: rtl/argmax_tree.sv
module argmax_tree #(
  parameter int unsigned LANES      = 8,
  parameter int unsigned SLICE_LOG2 = 2,
  parameter int unsigned VAL_W      = 16,
  parameter int unsigned GRP_W      = 6,
  localparam int unsigned LANE_W    = $clog2(LANES),
  localparam int unsigned IDX_W     = GRP_W + LANE_W,
  localparam int unsigned NSL       = LANES >> SLICE_LOG2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   first_i,
  input  logic                   last_i,
  input  logic [LANES*VAL_W-1:0] data_i,
  input  logic [LANES-1:0]       mask_i,
  output logic                   valid_o,
  output logic [VAL_W-1:0]       max_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic                      s1_valid, s1_first, s1_last;
  logic [NSL-1:0][VAL_W-1:0] win_val;
  logic [NSL-1:0][IDX_W-1:0] win_idx;

  argmax_slice_stage #(
    .LANES(LANES), .SLICE_LOG2(SLICE_LOG2), .VAL_W(VAL_W), .GRP_W(GRP_W)
  ) u_stage1 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .first_i    (first_i),
    .last_i     (last_i),
    .data_i     (data_i),
    .mask_i     (mask_i),
    .s1_valid_o (s1_valid),
    .s1_first_o (s1_first),
    .s1_last_o  (s1_last),
    .win_val_o  (win_val),
    .win_idx_o  (win_idx)
  );

  argmax_merge #(.NSL(NSL), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_stage2 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .s1_valid_i (s1_valid),
    .s1_first_i (s1_first),
    .s1_last_i  (s1_last),
    .win_val_i  (win_val),
    .win_idx_i  (win_idx),
    .valid_o    (valid_o),
    .max_o      (max_o),
    .idx_o      (idx_o)
  );
endmodule

// File: tb/argmax_tree_tb_top.sv
module argmax_tree_tb_top;
  localparam int LANES = 8;
  localparam int VAL_W = 16;
  localparam int IDX_W = 9;

  typedef struct packed {
    logic [127:0] d;
    logic [7:0]   m;
    logic         f;
    logic         l;
    logic [15:0]  ev;
    logic [8:0]   ei;
  } row_t;

  // data written lane 7 first, lane 0 last
  localparam row_t ROWS [12] = '{
    '{{16'd7,16'd2,16'd0,16'd1,16'd9,16'd3,16'd9,16'd5}, 8'h00, 1'b1, 1'b1, 16'd9, 9'd1},
    '{{16'd0,16'd30,16'd0,16'd0,16'd0,16'd30,16'd0,16'd0}, 8'h00, 1'b1, 1'b1, 16'd30, 9'd2},
    '{{16'd8,16'd7,16'd6,16'd5,16'd4,16'd3,16'd2,16'd1}, 8'h00, 1'b1, 1'b0, 16'd0, 9'd0},
    '{{16'd0,16'd0,16'd100,16'd0,16'd0,16'd0,16'd0,16'd0}, 8'h00, 1'b0, 1'b0, 16'd0, 9'd0},
    '{{16'd50,16'd50,16'd50,16'd50,16'd50,16'd100,16'd50,16'd50}, 8'h00, 1'b0, 1'b1, 16'd100, 9'd13},
    '{{16'd80,16'd70,16'd60,16'd50,16'd40,16'd30,16'd20,16'd10}, 8'hC0, 1'b1, 1'b0, 16'd0, 9'd0},
    '{{8{16'd90}}, 8'hFF, 1'b0, 1'b1, 16'd60, 9'd5},
    '{{8{16'hFFFF}}, 8'hFF, 1'b1, 1'b1, 16'd0, 9'd0},
    '{{8{16'hFFFE}}, 8'h00, 1'b1, 1'b0, 16'd0, 9'd0},
    '{{16'hFFFF,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0}, 8'h00, 1'b0, 1'b1, 16'hFFFF, 9'd15},
    '{{8{16'd500}}, 8'h00, 1'b1, 1'b0, 16'd0, 9'd0},
    '{{16'd0,16'd0,16'd0,16'd0,16'd4,16'd0,16'd0,16'd0}, 8'h00, 1'b1, 1'b1, 16'd4, 9'd3}
  };
  localparam string ROW_REQ [12] = '{"R9","R3","R3","R2","R2","R4","R4","R4","R1","R1","R5","R5"};

  logic                   clk = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   valid_i = 1'b0, first_i = 1'b0, last_i = 1'b0;
  logic [LANES*VAL_W-1:0] data_i = '0;
  logic [LANES-1:0]       mask_i = '0;
  logic                   valid_o;
  logic [VAL_W-1:0]       max_o;
  logic [IDX_W-1:0]       idx_o;
  int                     n_chk = 0, n_fail = 0, cyc = 0;
  bit                     done = 1'b0;

  always #2.5 clk = ~clk;

  argmax_tree dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .first_i(first_i), .last_i(last_i),
    .data_i(data_i), .mask_i(mask_i), .valid_o(valid_o), .max_o(max_o), .idx_o(idx_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [127:0] d, input logic [7:0] m, input logic v,
                       input logic f, input logic l);
    @(negedge clk);
    valid_i = v; data_i = d; mask_i = m; first_i = f; last_i = l;
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk);
    chk("R8 reset valid", 32'(valid_o), 0);
    chk("R8 reset max", 32'(max_o), 0);
    chk("R8 reset idx", 32'(idx_o), 0);
    rst_ni = 1'b1;

    // table walk
    for (int r = 0; r < 12; r++) begin
      drive(ROWS[r].d, ROWS[r].m, 1'b1, ROWS[r].f, ROWS[r].l);
      if (ROWS[r].l) begin
        idle();
        @(posedge clk); #1;
        chk({ROW_REQ[r], " R6 valid"}, 32'(valid_o), 1);
        chk({ROW_REQ[r], " max"}, 32'(max_o), 32'(ROWS[r].ev));
        chk({ROW_REQ[r], " idx"}, 32'(idx_o), 32'(ROWS[r].ei));
        @(posedge clk); #1;
        chk("R6 pulse ends", 32'(valid_o), 0);
      end
    end

    // R7: idle cycles carrying junk do nothing
    drive({8{16'd3}}, 8'h00, 1'b1, 1'b1, 1'b0);
    drive({8{16'd999}}, 8'h00, 1'b0, 1'b1, 1'b1);
    drive({8{16'd999}}, 8'h00, 1'b0, 1'b1, 1'b1);
    #1 chk("R7 idle no result", 32'(valid_o), 0);
    drive({16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd5,16'd0}, 8'h00, 1'b1, 1'b0, 1'b1);
    idle();
    @(posedge clk); #1;
    chk("R7 valid", 32'(valid_o), 1);
    chk("R7 max", 32'(max_o), 5);
    chk("R7 idx", 32'(idx_o), 9);

    // R6 back-to-back single-group vectors
    drive({16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd11}, 8'h00, 1'b1, 1'b1, 1'b1);
    drive({16'd0,16'd12,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0}, 8'h00, 1'b1, 1'b1, 1'b1);
    idle();
    chk("R6 b2b A valid", 32'(valid_o), 1);
    chk("R6 b2b A max", 32'(max_o), 11);
    chk("R6 b2b A idx", 32'(idx_o), 0);
    @(negedge clk);
    chk("R6 b2b B valid", 32'(valid_o), 1);
    chk("R6 b2b B max", 32'(max_o), 12);
    chk("R5 b2b B idx", 32'(idx_o), 6);

    // R8 hold
    repeat (3) @(negedge clk);
    chk("R8 hold valid", 32'(valid_o), 0);
    chk("R8 hold max", 32'(max_o), 12);
    chk("R8 hold idx", 32'(idx_o), 6);

    done = 1'b1;
    finish_run();
  end
endmodule